// File: doc/BRIEF.md
# Time-of-Day Alarm with Repeat Masks

This block compares four stored alarm fields with the current time of a BCD real-time clock and raises an interrupt pulse when they agree. The four fields are seconds, minutes, hours and day-of-month. Bit 7 of each field is a repeat-mask flag. The pattern of these four flags sets how often the alarm repeats: monthly, daily, hourly, once a minute or once a second. Software programs the fields through a byte-wide register port. A write whose value is not a legal BCD number for that field is dropped, and the register keeps its previous contents.

The running time arrives from outside as four BCD bytes. A one-cycle seconds strobe arrives with it. On each strobe the block decides whether the alarm matches. If it does, the interrupt output goes high for exactly one cycle.

Top module: `tod_alarm`

## Requirements
- R1: After a synchronous reset, the seconds, minutes and hours registers hold 0x00, the date register holds 0x01, and `alarm_irq` is 0.
- R2: The register addresses are 0 = seconds, 1 = minutes, 2 = hours and 3 = date. `reg_rdata` combinationally returns the full stored byte at `reg_addr`, including bit 7.
- R3: A seconds or minutes write is stored as the whole byte only when bits 6:0 are valid BCD from 0 to 59. That means bits 6:4 are no more than 5 and bits 3:0 are no more than 9. Any other write leaves the register unchanged.
- R4: An hours write is stored as the whole byte only when bits 5:0 are valid BCD from 0 to 23. Any other write leaves the register unchanged.
- R5: A date write is stored as the whole byte only when bits 3:0 are no more than 9 and bits 5:0 are not zero. Any other write leaves the register unchanged.
- R6: When all four mask bits are 0, a strobe raises the interrupt only if all four fields match. Seconds and minutes are compared on bits 6:0. Hours and date are compared on bits 5:0.
- R7: When only the date mask is set, a strobe raises the interrupt if hours, minutes and seconds match.
- R8: When only the date and hours masks are set, a strobe raises the interrupt if minutes and seconds match.
- R9: When the date, hours and minutes masks are set and the seconds mask is clear, a strobe raises the interrupt if seconds match.
- R10: Any other mask pattern, including all four set, raises the interrupt on every strobe.
- R11: `alarm_irq` is high only in the cycle after a cycle in which `sec_tick` was high. A single strobe gives a pulse of exactly one cycle, and no interrupt occurs without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 seconds, 1 minutes, 2 hours, 3 date) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sec_tick | input | 1 | One-cycle strobe marking each new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The checker watches every write on every cycle. It confirms that a rejected write leaves the register untouched and that an accepted write stores the whole byte. It also confirms that the interrupt only ever follows a strobe, that the monthly and daily match rules hold, and that the every-second patterns always fire. The bench scenarios cover the things a single-cycle property cannot:
- the reset contents read back through the port;
- the hourly and per-minute repeat rules tried against deliberately mismatched fields;
- a matching time held without a strobe;
- a long random mix of legal and illegal writes checked against an independent model of the registers.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 4;
    localparam int ADDR_W     = $clog2(NUM_FIELDS);

    // Field index equals its register address; the order is decoded by software
    typedef enum logic [ADDR_W-1:0] {
        F_SEC  = 2'd0,
        F_MIN  = 2'd1,
        F_HOUR = 2'd2,
        F_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_e;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_bank_t;

    // Bits of each field that take part in the time comparison
    function automatic logic [BYTE_W-1:0] cmp_mask(field_e f);
        case (f)
            F_SEC, F_MIN: return 8'h7F;
            default:      return 8'h3F;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(field_e f);
        return (f == F_DATE) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic digit_ok(logic [3:0] n);
        return n <= 4'd9;
    endfunction

    // Range check applied to an incoming write
    function automatic logic write_ok(field_e f, logic [BYTE_W-1:0] v);
        logic ok;
        case (f)
            F_SEC, F_MIN: ok = digit_ok(v[3:0]) && (v[6:4] <= 3'd5);
            F_HOUR:       ok = digit_ok(v[3:0]) &&
                               ((v[5:4] < 2'd2) || ((v[5:4] == 2'd2) && (v[3:0] <= 4'd3)));
            default:      ok = digit_ok(v[3:0]) && (v[5:0] != 6'd0);
        endcase
        return ok;
    endfunction

    // masks[i] is the repeat flag of field i
    function automatic repeat_e decode_repeat(logic [NUM_FIELDS-1:0] masks);
        repeat_e r;
        case (masks)
            4'b0000: r = RPT_MONTH;
            4'b1000: r = RPT_DAY;
            4'b1100: r = RPT_HOUR;
            4'b1110: r = RPT_MINUTE;
            default: r = RPT_SECOND;
        endcase
        return r;
    endfunction

    // How many fields, counted upward from seconds, must match
    function automatic int unsigned fields_needed(repeat_e r);
        int unsigned n;
        case (r)
            RPT_MONTH:  n = 4;
            RPT_DAY:    n = 3;
            RPT_HOUR:   n = 2;
            RPT_MINUTE: n = 1;
            default:    n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    output field_bank_t           bank_q
);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam field_e KIND = field_e'(i);
        logic [BYTE_W-1:0] q;
        logic              take;

        assign take = wr_en && (wr_addr == ADDR_W'(i)) && write_ok(KIND, wr_data);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reset_value(KIND);
            end else if (take) begin
                q <= wr_data;
            end
        end

        assign bank_q[i] = q;
    end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  field_bank_t bank,
    input  field_bank_t now,
    output logic        hit
);

    logic [NUM_FIELDS-1:0] masks;
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] need;
    repeat_e               mode;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam field_e KIND = field_e'(i);
        assign masks[i] = bank[i][BYTE_W-1];
        assign eq[i]    = ((bank[i] ^ now[i]) & cmp_mask(KIND)) == '0;
        assign need[i]  = i < fields_needed(mode);
    end

    always_comb begin
        mode = decode_repeat(masks);
        hit  = &(eq | ~need);
    end

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                sec_tick,
    input  logic [7:0]          now_sec,
    input  logic [7:0]          now_min,
    input  logic [7:0]          now_hour,
    input  logic [7:0]          now_date,
    output logic                alarm_irq
);

    field_bank_t bank;
    field_bank_t now;
    logic        hit;
    logic        irq_q;

    assign now[F_SEC]  = now_sec;
    assign now[F_MIN]  = now_min;
    assign now[F_HOUR] = now_hour;
    assign now[F_DATE] = now_date;

    tod_alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .bank_q  (bank)
    );

    tod_alarm_match u_match (
        .bank (bank),
        .now  (now),
        .hit  (hit)
    );

    assign reg_rdata = bank[reg_addr];

    // Compare uses the registers as they stood before any same-cycle write
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= sec_tick && hit;
        end
    end

    assign alarm_irq = irq_q;

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             sec_tick,
    input logic [7:0]       now_sec,
    input logic [7:0]       now_min,
    input logic [7:0]       now_hour,
    input logic [7:0]       now_date,
    input logic             alarm_irq,
    input logic [3:0][7:0]  bank
);

    logic       sec_bad, hour_bad, date_bad;
    logic [3:0] flags;
    logic       s_eq, m_eq, h_eq, d_eq;
    logic       other_pattern;

    assign sec_bad  = (reg_wdata[3:0] > 4'd9) || (reg_wdata[6:4] > 3'd5);
    assign hour_bad = (reg_wdata[3:0] > 4'd9) || (reg_wdata[5:4] == 2'd3) ||
                      ((reg_wdata[5:4] == 2'd2) && (reg_wdata[3:0] > 4'd3));
    assign date_bad = (reg_wdata[3:0] > 4'd9) || (reg_wdata[5:0] == 6'd0);

    assign flags = {bank[3][7], bank[2][7], bank[1][7], bank[0][7]};
    assign s_eq  = bank[0][6:0] == now_sec[6:0];
    assign m_eq  = bank[1][6:0] == now_min[6:0];
    assign h_eq  = bank[2][5:0] == now_hour[5:0];
    assign d_eq  = bank[3][5:0] == now_date[5:0];
    assign other_pattern = (flags != 4'b0000) && (flags != 4'b1000) &&
                           (flags != 4'b1100) && (flags != 4'b1110);

    p_irq_after_tick_r11: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(sec_tick));

    p_keep_sec_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && sec_bad) |=> bank[0] == $past(bank[0]));

    p_take_min_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && !sec_bad) |=> bank[1] == $past(reg_wdata));

    p_keep_hour_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && hour_bad) |=> bank[2] == $past(bank[2]));

    p_take_hour_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && !hour_bad) |=> bank[2] == $past(reg_wdata));

    p_keep_date_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && date_bad) |=> bank[3] == $past(bank[3]));

    p_month_hit_r6: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && flags == 4'b0000 && s_eq && m_eq && h_eq && d_eq) |=> alarm_irq);

    p_month_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && flags == 4'b0000 && !(s_eq && m_eq && h_eq && d_eq)) |=> !alarm_irq);

    p_day_hit_r7: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && flags == 4'b1000 && s_eq && m_eq && h_eq) |=> alarm_irq);

    p_every_second_r10: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && other_pattern) |=> alarm_irq);

endmodule

bind tod_alarm tod_alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sec_tick  (sec_tick),
    .now_sec   (now_sec),
    .now_min   (now_min),
    .now_hour  (now_hour),
    .now_date  (now_date),
    .alarm_irq (alarm_irq),
    .bank      (bank)
);

// File: tb/tb_tod_alarm.sv
module tb_tod_alarm;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h00;
    logic       alarm_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_alarm dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic legal(int idx, logic [7:0] v);
        int lo, hi;
        lo = v[3:0];
        if (lo > 9) return 1'b0;
        if (idx < 2) begin
            hi = v[6:4];
            return (hi * 10 + lo) <= 59;
        end
        hi = v[5:4];
        if (idx == 2) return (hi * 10 + lo) <= 23;
        return (hi * 10 + lo) != 0;
    endfunction

    function automatic logic model_irq(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
        logic se, me, he, de;
        se = mdl[0][6:0] == s[6:0];
        me = mdl[1][6:0] == m[6:0];
        he = mdl[2][5:0] == h[5:0];
        de = mdl[3][5:0] == d[5:0];
        case ({mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]})
            4'b0000: return se && me && he && de;
            4'b1000: return se && me && he;
            4'b1100: return se && me;
            4'b1110: return se;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string mode_tag();
        case ({mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]})
            4'b0000: return "R6";
            4'b1000: return "R7";
            4'b1100: return "R8";
            4'b1110: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [7:0] v);
        reg_wr = 1'b1; reg_addr = 2'(idx); reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        if (legal(idx, v)) mdl[idx] = v;
    endtask

    task automatic rd(int idx, string tag);
        reg_addr = 2'(idx);
        #1;
        chk(tag, reg_rdata, mdl[idx]);
    endtask

    task automatic tick(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d, string tag);
        logic e;
        e = model_irq(s, m, h, d);
        now_sec = s; now_min = m; now_hour = h; now_date = d;
        sec_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        sec_tick = 1'b0;
        chk(tag, {7'd0, alarm_irq}, {7'd0, e});
        @(posedge clk); @(negedge clk);
        chk("R11", {7'd0, alarm_irq}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'h00; mdl[3] = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) rd(i, "R1");
        chk("R1", {7'd0, alarm_irq}, 8'h00);

        // R3 seconds and minutes
        wr(0, 8'h59); rd(0, "R3");
        wr(0, 8'h60); rd(0, "R3");
        wr(0, 8'h5A); rd(0, "R3");
        wr(1, 8'h85); rd(1, "R2");
        wr(1, 8'h00); rd(1, "R3");
        // R4 hours
        wr(2, 8'h23); rd(2, "R4");
        wr(2, 8'h24); rd(2, "R4");
        wr(2, 8'h1A); rd(2, "R4");
        wr(2, 8'hC7); rd(2, "R4");
        // R5 date
        wr(3, 8'h00); rd(3, "R5");
        wr(3, 8'h80); rd(3, "R5");
        wr(3, 8'h31); rd(3, "R5");
        wr(3, 8'h0A); rd(3, "R5");

        // R6 monthly
        wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h05); wr(3, 8'h15);
        tick(8'h10, 8'h20, 8'h05, 8'h15, "R6");
        tick(8'h10, 8'h20, 8'h05, 8'h16, "R6");
        // R11 no strobe, matching time
        now_sec = 8'h10; now_min = 8'h20; now_hour = 8'h05; now_date = 8'h15;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R11", {7'd0, alarm_irq}, 8'h00);
        end
        // R7 daily
        wr(3, 8'h95);
        tick(8'h10, 8'h20, 8'h05, 8'h02, "R7");
        tick(8'h10, 8'h20, 8'h06, 8'h15, "R7");
        // R8 hourly
        wr(2, 8'h85);
        tick(8'h10, 8'h20, 8'h11, 8'h07, "R8");
        tick(8'h10, 8'h21, 8'h05, 8'h15, "R8");
        // R9 per minute
        wr(1, 8'hA0);
        tick(8'h10, 8'h44, 8'h11, 8'h07, "R9");
        tick(8'h11, 8'h20, 8'h05, 8'h15, "R9");
        // R10 other patterns
        wr(1, 8'h20); wr(2, 8'h05); wr(3, 8'h15); wr(0, 8'h90);
        tick(8'h33, 8'h01, 8'h02, 8'h03, "R10");
        wr(1, 8'hA0); wr(2, 8'h85); wr(3, 8'h95);
        tick(8'h00, 8'h00, 8'h00, 8'h01, "R10");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int idx;
            logic [7:0] v;
            idx = int'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) begin
                v = $urandom_range(0, 255);
            end else begin
                case (idx)
                    0, 1:    v = bcd(int'($urandom_range(0, 59)));
                    2:       v = bcd(int'($urandom_range(0, 23)));
                    default: v = bcd(int'($urandom_range(1, 31)));
                endcase
                v[7] = ($urandom_range(0, 3) == 0);
                if (idx >= 2) v[6] = $urandom_range(0, 1) == 1;
            end
            wr(idx, v);
            rd(idx, "R2");
            if ($urandom_range(0, 1) == 1) begin
                logic [7:0] t [4];
                t[0] = {1'b0, mdl[0][6:0]};
                t[1] = {1'b0, mdl[1][6:0]};
                t[2] = {2'b0, mdl[2][5:0]};
                t[3] = {2'b0, mdl[3][5:0]};
                if ($urandom_range(0, 1) == 1) begin
                    int f;
                    f = int'($urandom_range(0, 3));
                    case (f)
                        0, 1:    t[f] = bcd(int'($urandom_range(0, 59)));
                        2:       t[f] = bcd(int'($urandom_range(0, 23)));
                        default: t[f] = bcd(int'($urandom_range(1, 31)));
                    endcase
                end
                tick(t[0], t[1], t[2], t[3], mode_tag());
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule